// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an 8192 x 8 asynchronous static RAM that shares one bidirectional data bus. The host issues one word access at a time over a request/ready handshake, carrying a write flag, a 13-bit address and write data. The block converts each request into the RAM's pin sequence. It drives the address, an active-low and an active-high chip select, an output enable and a write strobe. It also drives a data output with its own drive-enable, which lets the pad or tristate logic outside the block own the bus.

The length of every phase is a cycle count computed at elaboration time. Each count is the ceiling of a nanosecond timing parameter divided by the clock period parameter, and never less than one cycle. Reads hold the RAM selected with its outputs enabled for the access time, then deselect it for a float-time turnaround before the next access. Writes keep the output enable high for the whole access. The block's own driver turns on one cycle after the write strobe falls and turns off on the edge where the strobe rises, so the two sides never drive the bus at the same time.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While `rst_ni` is low and after it rises with no request, `ram_ce_no`=1, `ram_ce_o`=0, `ram_oe_no`=1, `ram_we_no`=1, `ram_dq_oe_o`=0, `rvalid_o`=0 and `ready_o`=1.
- R2: A request is taken on a clock edge where `req_i` and `ready_o` are both 1. `ready_o` is 0 from the next cycle until the access and its turnaround end.
- R3: A read holds `ram_ce_no`=0, `ram_ce_o`=1, `ram_oe_no`=0 and `ram_we_no`=1 for NR = max(ceil(T_RC/CLK), ceil(T_AA/CLK)) cycles, which is 10 with the defaults. It then deselects the RAM and keeps `ready_o` low for NT = ceil(T_HZ/CLK) cycles (5 by default).
- R4: `rdata_o` takes the `ram_dq_i` value present on the last selected read cycle. `rvalid_o` is 1 for exactly the one following cycle.
- R5: A write first spends one cycle selected with `ram_we_no`=1. It then holds `ram_we_no`=0 for NW = max(ceil(T_CW/CLK), ceil(T_AW/CLK), 1+ceil(T_DW/CLK)) cycles (7 by default). The chip selects go inactive on the same edge where `ram_we_no` rises.
- R6: `ram_dq_oe_o` is 1 only while `ram_we_no` is 0, except on the first such cycle, and falls on the edge where `ram_we_no` rises. While it is 1, `ram_dq_o` equals the request's write data.
- R7: `ram_oe_no` stays 1 throughout a write, so the RAM and the block never drive the data bus in the same cycle.
- R8: `ram_addr_o` equals the request's address and does not change while the RAM is selected.
- R9: After a write strobe ends, the RAM stays deselected for NR2 = max(1, ceil(T_WC/CLK) - NW - 1) cycles (2 by default) before `ready_o` returns to 1.
- R10: A `req_i` asserted while `ready_o` is 0 is ignored. It starts no access and changes no memory word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 13 | Word address |
| wdata_i | input | 8 | Write data |
| ready_o | output | 1 | Idle and able to take a request |
| rvalid_o | output | 1 | One-cycle read data valid pulse |
| rdata_o | output | 8 | Read data |
| ram_addr_o | output | 13 | RAM address |
| ram_ce_no | output | 1 | RAM chip select, active low |
| ram_ce_o | output | 1 | RAM chip select, active high |
| ram_oe_no | output | 1 | RAM output enable, active low |
| ram_we_no | output | 1 | RAM write strobe, active low |
| ram_dq_o | output | 8 | Data toward the RAM |
| ram_dq_oe_o | output | 1 | Drive enable for `ram_dq_o` |
| ram_dq_i | input | 8 | Data from the RAM |

## Verification
A phase counter that loads the wrong value shows up within one access as a strobe run that is too long or too short. It also moves the edge at which `ready_o` returns. A sequencer that slips into the wrong state shows up at once as a pin combination that must never occur, such as the driver on while the output enable is low or the selects active during a turnaround cycle. The bench compares every pin on every cycle of each access against a schedule built from the parameters. Contention and address changes are therefore caught on the cycle they happen, and lost or corrupted data is caught on the next read of that word.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RD,
    PH_RTURN,
    PH_WSET,
    PH_WSTRB,
    PH_WREC
  } phase_e;

  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int unsigned N_RD  = 10,
  parameter int unsigned N_RT  = 5,
  parameter int unsigned N_WL  = 7,
  parameter int unsigned N_WR  = 2,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  output logic             ready_o,
  output logic             accept_o,
  output logic             rd_last_o,
  output phase_e           phase_d_o,
  output logic [CNT_W-1:0] cnt_d_o
);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;

  assign cnt_zero  = (cnt_q == '0);
  assign ready_o   = (phase_q == PH_IDLE);
  assign accept_o  = ready_o && req_i;
  assign rd_last_o = (phase_q == PH_RD) && cnt_zero;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_zero ? cnt_q : cnt_q - 1'b1;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_i) begin
          phase_d = we_i ? PH_WSET : PH_RD;
          cnt_d   = we_i ? '0 : CNT_W'(N_RD - 1);
        end
      end
      PH_RD: begin
        if (cnt_zero) begin
          phase_d = PH_RTURN;
          cnt_d   = CNT_W'(N_RT - 1);
        end
      end
      PH_RTURN: if (cnt_zero) phase_d = PH_IDLE;
      PH_WSET: begin
        phase_d = PH_WSTRB;
        cnt_d   = CNT_W'(N_WL - 1);
      end
      PH_WSTRB: begin
        if (cnt_zero) begin
          phase_d = PH_WREC;
          cnt_d   = CNT_W'(N_WR - 1);
        end
      end
      PH_WREC: if (cnt_zero) phase_d = PH_IDLE;
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase_d_o = phase_d;
  assign cnt_d_o   = cnt_d;

endmodule

// File: rtl/sram_seq_pins.sv
module sram_seq_pins
  import sram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned N_WL   = 7,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  phase_e            phase_d_i,
  input  logic [CNT_W-1:0]  cnt_d_i,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_ce_no,
  output logic              ram_ce_o,
  output logic              ram_oe_no,
  output logic              ram_we_no,
  output logic [DATA_W-1:0] ram_dq_o,
  output logic              ram_dq_oe_o
);

  logic sel_d, strobe_first_d;

  // Pins are registered from the next phase so each strobe changes cleanly on a clock edge
  assign sel_d          = (phase_d_i == PH_RD) || (phase_d_i == PH_WSET) || (phase_d_i == PH_WSTRB);
  assign strobe_first_d = (cnt_d_i == CNT_W'(N_WL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ram_ce_no   <= 1'b1;
      ram_ce_o    <= 1'b0;
      ram_oe_no   <= 1'b1;
      ram_we_no   <= 1'b1;
      ram_dq_oe_o <= 1'b0;
    end else begin
      ram_ce_no   <= !sel_d;
      ram_ce_o    <= sel_d;
      ram_oe_no   <= (phase_d_i != PH_RD);
      ram_we_no   <= (phase_d_i != PH_WSTRB);
      ram_dq_oe_o <= (phase_d_i == PH_WSTRB) && !strobe_first_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ram_addr_o <= '0;
      ram_dq_o   <= '0;
    end else if (accept_i) begin
      ram_addr_o <= addr_i;
      ram_dq_o   <= wdata_i;
    end
  end

endmodule

// File: rtl/sram_seq_rdcap.sv
module sram_seq_rdcap #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_last_i,
  input  logic [DATA_W-1:0] ram_dq_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_last_i;
      if (rd_last_i) rdata_o <= ram_dq_i;
    end
  end

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CLK_NS  = 10,
  parameter int unsigned T_RC_NS = 100,
  parameter int unsigned T_AA_NS = 100,
  parameter int unsigned T_HZ_NS = 45,
  parameter int unsigned T_WC_NS = 100,
  parameter int unsigned T_CW_NS = 70,
  parameter int unsigned T_AW_NS = 70,
  parameter int unsigned T_DW_NS = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_ce_no,
  output logic              ram_ce_o,
  output logic              ram_oe_no,
  output logic              ram_we_no,
  output logic [DATA_W-1:0] ram_dq_o,
  output logic              ram_dq_oe_o,
  input  logic [DATA_W-1:0] ram_dq_i
);

  localparam int unsigned N_RD  = umax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS));
  localparam int unsigned N_RT  = ns_to_cyc(T_HZ_NS, CLK_NS);
  localparam int unsigned N_WL  = umax(umax(ns_to_cyc(T_CW_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS)),
                                       1 + ns_to_cyc(T_DW_NS, CLK_NS));
  localparam int unsigned N_WC  = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int unsigned N_WR  = (N_WC > N_WL + 2) ? N_WC - N_WL - 1 : 1;
  localparam int unsigned N_MAX = umax(umax(N_RD, N_RT), umax(N_WL, N_WR));
  localparam int unsigned CNT_W = $clog2(N_MAX + 1);

  phase_e           phase_d;
  logic [CNT_W-1:0] cnt_d;
  logic             accept, rd_last;

  sram_seq_fsm #(
    .N_RD (N_RD),
    .N_RT (N_RT),
    .N_WL (N_WL),
    .N_WR (N_WR),
    .CNT_W(CNT_W)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .ready_o  (ready_o),
    .accept_o (accept),
    .rd_last_o(rd_last),
    .phase_d_o(phase_d),
    .cnt_d_o  (cnt_d)
  );

  sram_seq_pins #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .N_WL  (N_WL),
    .CNT_W (CNT_W)
  ) u_pins (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .phase_d_i  (phase_d),
    .cnt_d_i    (cnt_d),
    .ram_addr_o (ram_addr_o),
    .ram_ce_no  (ram_ce_no),
    .ram_ce_o   (ram_ce_o),
    .ram_oe_no  (ram_oe_no),
    .ram_we_no  (ram_we_no),
    .ram_dq_o   (ram_dq_o),
    .ram_dq_oe_o(ram_dq_oe_o)
  );

  sram_seq_rdcap #(
    .DATA_W(DATA_W)
  ) u_rdcap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_last_i(rd_last),
    .ram_dq_i (ram_dq_i),
    .rvalid_o (rvalid_o),
    .rdata_o  (rdata_o)
  );

endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              ready_o,
  input logic              rvalid_o,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic              ram_ce_no,
  input logic              ram_ce_o,
  input logic              ram_oe_no,
  input logic              ram_we_no,
  input logic              ram_dq_oe_o
);

  a_r2_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> !ready_o);

  a_r3_read_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_oe_no |-> (ram_we_no && !ram_ce_no && ram_ce_o));

  a_r4_rvalid_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> ($past(!ram_oe_no) && ram_oe_no));

  a_r5_deselect_with_we_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_we_no) |-> (ram_ce_no && !ram_ce_o));

  a_r6_drv_inside_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_dq_oe_o |-> !ram_we_no);

  a_r6_no_drv_on_first_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ram_we_no) |-> !ram_dq_oe_o);

  a_r7_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_dq_oe_o |-> ram_oe_no);

  a_r8_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ram_ce_no && $past(!ram_ce_no)) |-> $stable(ram_addr_o));

endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .ready_o    (ready_o),
  .rvalid_o   (rvalid_o),
  .ram_addr_o (ram_addr_o),
  .ram_ce_no  (ram_ce_no),
  .ram_ce_o   (ram_ce_o),
  .ram_oe_no  (ram_oe_no),
  .ram_we_no  (ram_we_no),
  .ram_dq_oe_o(ram_dq_oe_o)
);

// File: tb/sram_seq_ctrl_test.sv
module sram_seq_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;
  localparam int DW = 8;

  function automatic int cdiv(int ns);
    int c;
    c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int NR  = imax(cdiv(100), cdiv(100));
  localparam int NT  = cdiv(45);
  localparam int NW  = imax(imax(cdiv(70), cdiv(70)), 1 + cdiv(40));
  localparam int NR2 = imax(1, cdiv(100) - NW - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic ready, rvalid;
  logic [DW-1:0] rdata;
  logic [AW-1:0] ram_addr;
  logic ce_n, ce, oe_n, we_n, dq_oe;
  logic [DW-1:0] dq_o;
  logic [DW-1:0] dq_i = '0;

  int checks = 0, fails = 0, contention = 0;
  bit done = 0;

  logic [DW-1:0] model_mem [int];
  logic [DW-1:0] exp_mem [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_seq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ready_o(ready), .rvalid_o(rvalid), .rdata_o(rdata),
    .ram_addr_o(ram_addr), .ram_ce_no(ce_n), .ram_ce_o(ce), .ram_oe_no(oe_n),
    .ram_we_no(we_n), .ram_dq_o(dq_o), .ram_dq_oe_o(dq_oe), .ram_dq_i(dq_i)
  );

  function automatic logic [DW-1:0] blank_word(logic [AW-1:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction

  // Behavioural RAM: stores while selected with strobe low and data driven
  always @(posedge clk) begin
    if (!ce_n && ce && !we_n && dq_oe) model_mem[int'(ram_addr)] = dq_o;
  end

  always @(negedge clk) begin
    logic dev_drv;
    dev_drv = !ce_n && ce && !oe_n && we_n;
    if (dev_drv && dq_oe) contention++;
    if (dev_drv)
      dq_i <= model_mem.exists(int'(ram_addr)) ? model_mem[int'(ram_addr)] : blank_word(ram_addr);
    else
      dq_i <= 8'h00;
  end

  task automatic chk(bit ok, string req_tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req_tag, act, exp, $time);
    end
  endtask

  // bundle: {ce_n, ce, oe_n, we_n, dq_oe, ready}
  function automatic logic [5:0] exp_pins(bit wr, int i);
    if (!wr) begin
      if (i < NR)       return 6'b010100;
      if (i < NR + NT)  return 6'b101100;
      return 6'b101101;
    end
    if (i == 0)           return 6'b011100;
    if (i <= NW)          return {4'b0110, (i >= 2), 1'b0};
    if (i <= NW + NR2)    return 6'b101100;
    return 6'b101101;
  endfunction

  task automatic access(bit wr, logic [AW-1:0] a, logic [DW-1:0] d, bit poke);
    int total;
    logic [DW-1:0] exp_rd;
    exp_rd = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : blank_word(a);
    @(negedge clk);
    chk(ready === 1'b1, "R2", ready, 1);
    req = 1'b1; we = wr; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    total = wr ? (NW + NR2 + 1) : (NR + NT + 1);
    for (int i = 0; i < total; i++) begin
      logic [5:0] act, exp;
      if (poke && i == 2) begin req = 1'b1; we = 1'b1; addr = a ^ 13'h0155; wdata = 8'h3C; end
      if (poke && i == 4) begin req = 1'b0; we = 1'b0; addr = '0; wdata = '0; end
      act = {ce_n, ce, oe_n, we_n, dq_oe, ready};
      exp = exp_pins(wr, i);
      if (wr) chk(act === exp, (i > NW) ? "R9" : "R5 R6 R7", act, exp);
      else    chk(act === exp, "R3 R2", act, exp);
      if (!ce_n) chk(ram_addr === a, "R8", ram_addr, a);
      if (dq_oe) chk(dq_o === d, "R6", dq_o, d);
      if (!wr) begin
        chk(rvalid === (i == NR), "R4 pulse", rvalid, (i == NR));
        if (i == NR) chk(rdata === exp_rd, "R4 data", rdata, exp_rd);
      end
      @(negedge clk);
    end
    if (wr) exp_mem[int'(a)] = d;
  endtask

  task automatic idle_check(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(ce_n === 1'b1 && ready === 1'b1, "R10 no access", {ce_n, ready}, 2'b11);
    end
  endtask

  initial begin
    logic [AW-1:0] a0;
    #(CLK_PERIOD * 3 + 2);
    chk({ce_n, ce, oe_n, we_n, dq_oe, rvalid, ready} === 7'b1011001, "R1 in reset",
        {ce_n, ce, oe_n, we_n, dq_oe, rvalid, ready}, 7'b1011001);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({ce_n, ce, oe_n, we_n, dq_oe, rvalid, ready} === 7'b1011001, "R1 after reset",
        {ce_n, ce, oe_n, we_n, dq_oe, rvalid, ready}, 7'b1011001);

    // directed corners
    access(1'b0, 13'h0000, 8'h00, 1'b0);          // unwritten word
    access(1'b1, 13'h1FFF, 8'hFF, 1'b0);          // top address, all ones
    access(1'b1, 13'h0000, 8'h00, 1'b0);          // bottom address, all zeros
    access(1'b0, 13'h1FFF, 8'h00, 1'b0);
    access(1'b0, 13'h0000, 8'h00, 1'b0);
    access(1'b1, 13'h0AAA, 8'h5A, 1'b0);
    access(1'b0, 13'h0AAA, 8'h00, 1'b1);          // R10: write request during busy read
    idle_check(4);
    a0 = 13'h0AAA ^ 13'h0155;
    access(1'b0, a0, 8'h00, 1'b0);                // R10: poked word unchanged
    access(1'b1, 13'h0AAA, 8'hC3, 1'b1);          // R10: request during busy write
    idle_check(3);
    access(1'b0, a0, 8'h00, 1'b0);
    access(1'b0, 13'h0AAA, 8'h00, 1'b0);

    // constrained random mix over a small address window to force reuse
    void'($urandom(32'd7331));
    for (int k = 0; k < 120; k++) begin
      logic [AW-1:0] ra;
      ra = AW'($urandom_range(0, 31)) | (($urandom_range(0, 1) != 0) ? 13'h1FE0 : 13'h0000);
      access(($urandom_range(0, 2) == 0), ra, DW'($urandom), 1'b0);
    end
    chk(contention == 0, "R7 bus contention", contention, 0);

    // reset in the middle of a write strobe returns pins to idle levels
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 13'h0123; wdata = 8'h99;
    @(negedge clk);
    req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk({ce_n, ce, oe_n, we_n, dq_oe, ready} === 6'b101101, "R1 mid-access reset",
        {ce_n, ce, oe_n, we_n, dq_oe, ready}, 6'b101101);
    @(negedge clk);
    rst_n = 1'b1;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule